// File: doc/BRIEF.md
# Radar Frame Packetizer

This block turns one radar frame into a byte-serial bulk stream for a USB FIFO bridge. A one-cycle frame start latches a 3-bit stream mask and a 16-bit frame number. The block then sends a 9-byte header, then the enabled payload streams, then a one-byte trailer. The payload streams are the range profile, the row-major Doppler magnitude map and the 2-bit detection-class bitmap. Three upstream sources feed the payload: range words, Doppler magnitude words and detection classes. Each source has its own valid/ready pair. The block pulls data only from the stream it is currently sending.

The output is a registered byte with valid/ready. A byte stays where it is until the sink takes it. The range bin count and the Doppler bin count are parameters. A frame holds RANGE_BINS range words. It also holds RANGE_BINS x DOPPLER_BINS Doppler words and the same number of detection cells.

Top module: `radar_frame_packer`

## Requirements
- R1: The first byte of every frame is 0xAA and the second is the format version 0x02.
- R2: The third byte is {5'b00000, mask[2], mask[1], mask[0]}. Mask bit 0 enables the range profile, bit 1 the Doppler map and bit 2 the detection bitmap.
- R3: Bytes 3..8 carry three 16-bit fields, each high byte first: the latched frame number, then RANGE_BINS, then DOPPLER_BINS.
- R4: Enabled payloads follow the header in the fixed order range, Doppler, detections. Each 16-bit word is sent high byte first, in arrival order. At most one source ready is high in any cycle.
- R5: Detection cell N is placed in payload byte N/4 at bits [7-2*(N%4) -: 2], four cells per byte.
- R6: When the cell count is not a multiple of four, the unused low bit pairs of the last bitmap byte are zero.
- R7: The last byte of every frame is 0x55. Busy falls in the same cycle that this byte is loaded into the output register.
- R8: A disabled stream adds no bytes to the frame. Its source ready never rises, so none of its data is consumed.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_byte keeps its value on the next cycle. No byte is dropped or repeated.
- R10: A frame start that arrives while busy is high is ignored. The running frame keeps its header fields, and no second frame follows.
- R11: After reset, out_valid, busy and all three source readies are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Starts a frame when the block is idle |
| stream_mask | input | 3 | Stream enables: bit0 range, bit1 Doppler, bit2 detections |
| frame_num | input | 16 | Frame number placed in the header |
| rng_data | input | 16 | Range profile word |
| rng_valid | input | 1 | Range word valid |
| rng_ready | output | 1 | Range word accepted |
| dop_data | input | 16 | Doppler magnitude word |
| dop_valid | input | 1 | Doppler word valid |
| dop_ready | output | 1 | Doppler word accepted |
| det_class | input | 2 | Detection class of one cell |
| det_valid | input | 1 | Detection class valid |
| det_ready | output | 1 | Detection class accepted |
| out_byte | output | 8 | Output byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the output byte |
| busy | output | 1 | A frame is being assembled |

## Verification
The bench builds the block with RANGE_BINS=3 and DOPPLER_BINS=2. That gives six detection cells, which is not a multiple of four, so the padded second bitmap byte shows up in every frame that has detections enabled. With these sizes a full frame is 30 bytes. Every mask combination the tests use is then short enough to compare byte for byte, under a free-flowing sink and also under irregular sink and source stalls.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HDR  = 3'd1,
    ST_RNG  = 3'd2,
    ST_DOP  = 3'd3,
    ST_DET  = 3'd4,
    ST_FOOT = 3'd5
  } pk_state_t;

  localparam logic [7:0] SYNC_BYTE    = 8'hAA;
  localparam logic [7:0] VERSION_BYTE = 8'h02;
  localparam logic [7:0] TRAIL_BYTE   = 8'h55;
  localparam int         HDR_LEN      = 9;
endpackage

// File: rtl/rfp_header_mux.sv
module rfp_header_mux
  import rfp_pkg::*;
#(
  parameter int RANGE_BINS   = 512,
  parameter int DOPPLER_BINS = 48
) (
  input  logic [3:0]  idx,
  input  logic [2:0]  mask,
  input  logic [15:0] fnum,
  output logic [7:0]  hbyte
);
  localparam logic [15:0] RB16 = 16'(RANGE_BINS);
  localparam logic [15:0] DB16 = 16'(DOPPLER_BINS);

  always_comb begin
    case (idx)
      4'd0:    hbyte = SYNC_BYTE;
      4'd1:    hbyte = VERSION_BYTE;
      4'd2:    hbyte = {5'b00000, mask};
      4'd3:    hbyte = fnum[15:8];
      4'd4:    hbyte = fnum[7:0];
      4'd5:    hbyte = RB16[15:8];
      4'd6:    hbyte = RB16[7:0];
      4'd7:    hbyte = DB16[15:8];
      4'd8:    hbyte = DB16[7:0];
      default: hbyte = 8'h00;
    endcase
  end
endmodule

// File: rtl/rfp_det_packer.sv
module rfp_det_packer (
  input  logic       clk,
  input  logic       rst,
  input  logic       take,
  input  logic [1:0] cls,
  input  logic       last,
  input  logic       drain,
  output logic       full,
  output logic [7:0] acc
);
  logic [1:0] slot;

  always_ff @(posedge clk) begin
    if (rst || drain) begin
      acc  <= 8'h00;
      slot <= 2'd0;
      full <= 1'b0;
    end else if (take) begin
      acc[(3 - slot) * 2 +: 2] <= cls;
      slot <= slot + 2'd1;
      if (slot == 2'd3 || last) full <= 1'b1;
    end
  end
endmodule

// File: rtl/rfp_out_stage.sv
module rfp_out_stage (
  input  logic       clk,
  input  logic       rst,
  input  logic       emit,
  input  logic [7:0] ebyte,
  input  logic       out_ready,
  output logic       load,
  output logic       out_valid,
  output logic [7:0] out_byte
);
  assign load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_byte  <= 8'h00;
    end else if (load) begin
      out_valid <= emit;
      if (emit) out_byte <= ebyte;
    end
  end
endmodule

// File: rtl/radar_frame_packer.sv
module radar_frame_packer
  import rfp_pkg::*;
#(
  parameter int RANGE_BINS   = 512,
  parameter int DOPPLER_BINS = 48
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        frame_start,
  input  logic [2:0]  stream_mask,
  input  logic [15:0] frame_num,
  input  logic [15:0] rng_data,
  input  logic        rng_valid,
  output logic        rng_ready,
  input  logic [15:0] dop_data,
  input  logic        dop_valid,
  output logic        dop_ready,
  input  logic [1:0]  det_class,
  input  logic        det_valid,
  output logic        det_ready,
  output logic [7:0]  out_byte,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        busy
);
  localparam int CELLS = RANGE_BINS * DOPPLER_BINS;
  localparam int CW    = $clog2(CELLS + 1);
  localparam logic [CW-1:0] RNG_LAST  = CW'(RANGE_BINS - 1);
  localparam logic [CW-1:0] CELL_LAST = CW'(CELLS - 1);
  localparam logic [CW-1:0] CELL_ALL  = CW'(CELLS);

  pk_state_t   state;
  logic [2:0]  en_q;
  logic [15:0] fnum_q;
  logic [3:0]  hidx;
  logic [CW-1:0] cnt;
  logic        half;
  logic [7:0]  low_q;
  logic [7:0]  hbyte, ebyte, acc;
  logic        emit, load, fire, full, det_take;

  function automatic pk_state_t after_stage(input logic [1:0] done, input logic [2:0] m);
    pk_state_t s;
    s = ST_FOOT;
    if (done < 2'd3 && m[2]) s = ST_DET;
    if (done < 2'd2 && m[1]) s = ST_DOP;
    if (done < 2'd1 && m[0]) s = ST_RNG;
    return s;
  endfunction

  rfp_header_mux #(.RANGE_BINS(RANGE_BINS), .DOPPLER_BINS(DOPPLER_BINS)) hdr_i (
    .idx(hidx), .mask(en_q), .fnum(fnum_q), .hbyte(hbyte)
  );

  rfp_det_packer pack_i (
    .clk(clk), .rst(rst), .take(det_take), .cls(det_class),
    .last(cnt == CELL_LAST), .drain(state == ST_DET && fire),
    .full(full), .acc(acc)
  );

  rfp_out_stage ostg_i (
    .clk(clk), .rst(rst), .emit(emit), .ebyte(ebyte), .out_ready(out_ready),
    .load(load), .out_valid(out_valid), .out_byte(out_byte)
  );

  assign busy     = (state != ST_IDLE);
  assign fire     = load && emit;
  assign det_take = det_valid && det_ready;

  always_comb begin
    emit      = 1'b0;
    ebyte     = 8'h00;
    rng_ready = 1'b0;
    dop_ready = 1'b0;
    det_ready = 1'b0;
    case (state)
      ST_HDR: begin
        emit  = 1'b1;
        ebyte = hbyte;
      end
      ST_RNG: begin
        if (half) begin
          emit  = 1'b1;
          ebyte = low_q;
        end else begin
          rng_ready = load;
          emit      = rng_valid;
          ebyte     = rng_data[15:8];
        end
      end
      ST_DOP: begin
        if (half) begin
          emit  = 1'b1;
          ebyte = low_q;
        end else begin
          dop_ready = load;
          emit      = dop_valid;
          ebyte     = dop_data[15:8];
        end
      end
      ST_DET: begin
        det_ready = !full && (cnt != CELL_ALL);
        emit      = full;
        ebyte     = acc;
      end
      ST_FOOT: begin
        emit  = 1'b1;
        ebyte = TRAIL_BYTE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      en_q   <= 3'b000;
      fnum_q <= 16'h0000;
      hidx   <= 4'd0;
      cnt    <= '0;
      half   <= 1'b0;
      low_q  <= 8'h00;
    end else begin
      case (state)
        ST_IDLE: if (frame_start) begin
          en_q   <= stream_mask;
          fnum_q <= frame_num;
          hidx   <= 4'd0;
          cnt    <= '0;
          half   <= 1'b0;
          state  <= ST_HDR;
        end
        ST_HDR: if (fire) begin
          hidx <= hidx + 4'd1;
          if (hidx == 4'(HDR_LEN - 1)) state <= after_stage(2'd0, en_q);
        end
        ST_RNG, ST_DOP: if (fire) begin
          if (!half) begin
            low_q <= (state == ST_RNG) ? rng_data[7:0] : dop_data[7:0];
            half  <= 1'b1;
          end else begin
            half <= 1'b0;
            if ((state == ST_RNG && cnt == RNG_LAST) ||
                (state == ST_DOP && cnt == CELL_LAST)) begin
              cnt   <= '0;
              state <= after_stage((state == ST_RNG) ? 2'd1 : 2'd2, en_q);
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_DET: begin
          if (det_take) cnt <= cnt + 1'b1;
          if (fire && cnt == CELL_ALL) begin
            cnt   <= '0;
            state <= ST_FOOT;
          end
        end
        ST_FOOT: if (fire) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rfp_checker.sv
module rfp_checker (
  input logic       clk,
  input logic       rst,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte,
  input logic       busy,
  input logic       rng_ready,
  input logic       dop_ready,
  input logic       det_ready,
  input logic [2:0] en_q
);
  // R9
  hold_byte_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_byte));

  // R4
  one_src_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rng_ready, dop_ready, det_ready}));

  // R8
  rng_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q[0] |-> !rng_ready);

  // R8
  dop_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q[1] |-> !dop_ready);

  // R8
  det_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q[2] |-> !det_ready);

  // R7
  trailer_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> out_valid && out_byte == 8'h55);

  // R11
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> !out_valid && !busy && !rng_ready && !dop_ready && !det_ready);
endmodule

bind radar_frame_packer rfp_checker chk_i (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_byte(out_byte), .busy(busy), .rng_ready(rng_ready),
  .dop_ready(dop_ready), .det_ready(det_ready), .en_q(en_q)
);

// File: tb/radar_frame_packer_tb_top.sv
module radar_frame_packer_tb_top;
  localparam int RB    = 3;
  localparam int DB    = 2;
  localparam int CELLS = RB * DB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 1'b0;
  logic [2:0] stream_mask = 3'b000;
  logic [15:0] frame_num = 16'h0000;
  logic [15:0] rng_data = 16'h0, dop_data = 16'h0;
  logic [1:0] det_class = 2'b00;
  logic rng_valid = 1'b0, dop_valid = 1'b0, det_valid = 1'b0, out_ready = 1'b0;
  logic rng_ready, dop_ready, det_ready, out_valid, busy;
  logic [7:0] out_byte;

  int total = 0;
  int bad = 0;

  logic [7:0] exp_b [64];
  string      exp_t [64];
  logic [7:0] got_b [64];
  int exp_n, got_n;

  always #4 clk = ~clk;

  radar_frame_packer #(.RANGE_BINS(RB), .DOPPLER_BINS(DB)) dut_i (
    .clk(clk), .rst(rst), .frame_start(frame_start), .stream_mask(stream_mask),
    .frame_num(frame_num), .rng_data(rng_data), .rng_valid(rng_valid),
    .rng_ready(rng_ready), .dop_data(dop_data), .dop_valid(dop_valid),
    .dop_ready(dop_ready), .det_class(det_class), .det_valid(det_valid),
    .det_ready(det_ready), .out_byte(out_byte), .out_valid(out_valid),
    .out_ready(out_ready), .busy(busy)
  );

  function automatic logic [15:0] rw(input int i);
    return 16'hA10F + 16'(i * 16'h0123);
  endfunction
  function automatic logic [15:0] dw(input int i);
    return 16'h5C3A ^ 16'(i * 16'h0305);
  endfunction
  function automatic logic [1:0] dc(input int i);
    return 2'((i * 3 + 1) % 4);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] b, input string t);
    exp_b[exp_n] = b;
    exp_t[exp_n] = t;
    exp_n++;
  endtask

  task automatic build(input logic [2:0] m, input logic [15:0] fn);
    logic [7:0] pb;
    exp_n = 0;
    push(8'hAA, "R1"); push(8'h02, "R1");
    push({5'b0, m}, "R2");
    push(fn[15:8], "R3"); push(fn[7:0], "R3");
    push(8'(RB >> 8), "R3"); push(8'(RB), "R3");
    push(8'(DB >> 8), "R3"); push(8'(DB), "R3");
    if (m[0]) for (int i = 0; i < RB; i++) begin
      push(rw(i) >> 8, "R4"); push(rw(i) & 16'hFF, "R4");
    end
    if (m[1]) for (int i = 0; i < CELLS; i++) begin
      push(dw(i) >> 8, "R4"); push(dw(i) & 16'hFF, "R4");
    end
    if (m[2]) for (int b = 0; b < (CELLS + 3) / 4; b++) begin
      pb = 8'h00;
      for (int s = 0; s < 4; s++)
        if (b * 4 + s < CELLS) pb[7 - 2 * s -: 2] = dc(b * 4 + s);
      push(pb, (b * 4 + 3 >= CELLS) ? "R6" : "R5");
    end
    push(8'h55, "R7");
  endtask

  // Runs one frame; bp enables stalls, restart re-pulses frame_start mid-frame.
  task automatic run_frame(input logic [2:0] m, input logic [15:0] fn,
                           input bit bp, input bit restart, input string name);
    int ri = 0, di = 0, ki = 0, cyc = 0;
    bit stall = 1'b0;
    logic [7:0] held = 8'h00;
    build(m, fn);
    got_n = 0;
    while ((got_n < exp_n || cyc < exp_n + 40) && cyc < 2000) begin
      @(negedge clk);
      if (stall) check(out_valid && out_byte == held, "R9 hold", out_byte, held);
      frame_start = (cyc == 0) || (restart && cyc == 6);
      stream_mask = (cyc == 0) ? m : ~m;
      frame_num   = (cyc == 0) ? fn : ~fn;
      out_ready = bp ? ((cyc * 7) % 5 > 1) : 1'b1;
      rng_valid = bp ? (cyc % 3 != 1) : 1'b1;
      dop_valid = bp ? (cyc % 4 != 2) : 1'b1;
      det_valid = bp ? (cyc % 5 != 3) : 1'b1;
      rng_data  = rw(ri);
      dop_data  = dw(di);
      det_class = dc(ki);
      #1;
      if (out_valid && out_ready) begin
        if (got_n < 64) got_b[got_n] = out_byte;
        got_n++;
      end
      if (rng_valid && rng_ready) ri++;
      if (dop_valid && dop_ready) di++;
      if (det_valid && det_ready) ki++;
      stall = out_valid && !out_ready;
      held  = out_byte;
      cyc++;
    end
    frame_start = 1'b0;
    check(got_n == exp_n, {"R10 length ", name}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      check(got_b[i] == exp_b[i], {exp_t[i], " ", name}, got_b[i], exp_b[i]);
    check(ri == (m[0] ? RB : 0), {"R8 range consumed ", name}, ri, m[0] ? RB : 0);
    check(di == (m[1] ? CELLS : 0), {"R8 doppler consumed ", name}, di, m[1] ? CELLS : 0);
    check(ki == (m[2] ? CELLS : 0), {"R8 det consumed ", name}, ki, m[2] ? CELLS : 0);
    check(!busy, {"R7 idle after frame ", name}, busy, 0);
  endtask

  task automatic t_reset();
    check(!out_valid && !busy, "R11 valid/busy", {out_valid, busy}, 0);
    check(!rng_ready && !dop_ready && !det_ready, "R11 readies",
          {rng_ready, dop_ready, det_ready}, 0);
  endtask

  task automatic t_full();        run_frame(3'b111, 16'h1234, 0, 0, "full");      endtask
  task automatic t_stalled();     run_frame(3'b111, 16'hBEEF, 1, 0, "stalled");   endtask
  task automatic t_range_only();  run_frame(3'b001, 16'h0007, 1, 0, "range");     endtask
  task automatic t_det_only();    run_frame(3'b100, 16'h8001, 0, 0, "det");       endtask
  task automatic t_no_payload();  run_frame(3'b000, 16'hFFFF, 1, 0, "empty");     endtask
  task automatic t_restart();     run_frame(3'b011, 16'h0A0B, 0, 1, "restart");   endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full();
    t_stalled();
    t_range_only();
    t_det_only();
    t_no_payload();
    t_restart();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule